// File: doc/BRIEF.md
# Processor Interrupt Control Unit

This block decides when a simple load/store processor leaves its instruction stream for the interrupt handler, and how it comes back. It watches `NLINES` level-sensitive request lines. It holds three control registers: an enable word whose bit 0 gates every request, a one-deep save of that word, and a per-line mask. Software moves data to and from these registers only through a dedicated write-control port and a read-control port. The register index is 0 for the enable word, 1 for the saved word and 3 for the mask.

Whenever the pipeline reports a completed instruction, the unit checks whether any unmasked line is high while the enable bit is set. If so, it accepts the interrupt. The enable word is copied into the save register, the enable bit is cleared, and in the following cycle the pipeline gets a redirect to one shared handler address together with a write of the following PC (current PC plus 4) into the return-address register. The lines have no hardware priority, so the handler finds the source by reading the `pending` vector or by polling devices. A return-from-exception strobe copies the saved word back into the enable word and redirects the PC to the return address supplied by the register file.

The sequencer has three states. `ST_RUN` is normal execution and the only state in which boundaries and returns are evaluated. `ST_ENTER` is the one-cycle redirect into the handler, reached from `ST_RUN` on acceptance. `ST_RETURN` is the one-cycle redirect back to the return address, reached from `ST_RUN` on a return strobe. Both redirect states go back to `ST_RUN` unconditionally.

Top module: `irq_ctl_unit`

## Requirements
- R1: After reset, control registers 0, 1 and 3 read as 0, `pending` is 0, and `pc_load` and `ea_we` are 0.
- R2: A write-control at index 0, 1 or 3 updates that register, and a read-control at the same index returns the value written in the cycle after the write. A write at any other index (2, 4 to 7) changes none of registers 0, 1 and 3, and reads of those indices return 0.
- R3: `pending` equals `irq & mask` at all times, whatever the value of the enable bit.
- R4: An interrupt is accepted only in a cycle where `insn_done` is 1, bit 0 of register 0 is 1 and `irq & mask` is nonzero. A masked line, a cleared enable bit, or the absence of `insn_done` produces no redirect.
- R5: In the cycle after acceptance, `pc_load` is 1 with `pc_target` equal to `HANDLER_ADDR`, and `ea_we` is 1 with `ea_wdata` equal to the accepted `cur_pc` plus 4, computed modulo 2^XLEN. Both outputs last exactly one cycle.
- R6: On acceptance, register 1 receives the whole of register 0, and register 0 keeps all of its bits except bit 0, which becomes 0.
- R7: When `eret` is 1, in the next cycle `pc_load` is 1, `pc_target` equals the `ea_in` sampled with the strobe, and `ea_we` is 0. Register 0 takes the value register 1 held when the strobe was sampled.
- R8: If a write-control to register 0 coincides with an acceptance, the acceptance is decided on the enable bit before the write. Register 1 then holds the written value, and register 0 holds the written value with bit 0 cleared.
- R9: If `eret` and an acceptable boundary arrive in the same cycle, only the return is carried out.
- R10: During a redirect cycle (`pc_load` is 1), `insn_done` and `eret` are ignored. Every redirect is followed by at least one cycle without a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all control registers |
| irq | input | NLINES | Level-sensitive request lines, equal priority |
| insn_done | input | 1 | An instruction completed in this cycle (boundary) |
| cur_pc | input | XLEN | PC of the instruction completing with `insn_done` |
| eret | input | 1 | Return-from-exception instruction executes |
| ea_in | input | XLEN | Return-address register value read for `eret` |
| ctl_we | input | 1 | Write-control strobe |
| ctl_waddr | input | 3 | Write-control register index |
| ctl_wdata | input | XLEN | Write-control data from a general register |
| ctl_raddr | input | 3 | Read-control register index |
| ctl_rdata | output | XLEN | Read-control data to a general register |
| pc_load | output | 1 | Redirect the PC this cycle |
| pc_target | output | XLEN | New PC when `pc_load` is 1 |
| ea_we | output | 1 | Write the return-address register |
| ea_wdata | output | XLEN | Return address (accepted PC plus 4) |
| pending | output | NLINES | `irq & mask`, for observation |

## Verification
Acceptance is tried in four ways: with the enable bit cleared, with only a masked line high, with a line high but no boundary, and with an enabled, unmasked line at a boundary. The first three must stay silent and the last must redirect, which separates the enable gate, the mask gate and the boundary gate from one another. The collision patterns are a return and a boundary together, a boundary held through the return cycle, and a write to register 0 together with acceptance. Each of these has exactly one correct outcome for the redirect order and the register contents. A last acceptance on the top line at the highest word address checks the mask across its full width and the wrap of the return address.

// File: rtl/icu_pkg.sv
package icu_pkg;

    // Control register index width and the indices the block decodes.
    localparam int CR_AW = 3;
    localparam logic [CR_AW-1:0] CR_ENABLE = 3'd0;
    localparam logic [CR_AW-1:0] CR_SAVE   = 3'd1;
    localparam logic [CR_AW-1:0] CR_MASK   = 3'd3;

    // Sequencer states: run, redirect into handler, redirect back.
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ENTER  = 2'd1,
        ST_RETURN = 2'd2
    } icu_state_e;

endpackage

// File: rtl/icu_pending.sv
module icu_pending #(
    parameter int NLINES = 32
) (
    input  logic [NLINES-1:0] irq,
    input  logic [NLINES-1:0] mask,
    input  logic              master_en,
    output logic [NLINES-1:0] pending,
    output logic              take_req
);

    // One gate per request line; no priority between them.
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assign pending[i] = irq[i] & mask[i];
    end

    assign take_req = master_en & (|pending);

endmodule

// File: rtl/icu_ctlregs.sv
module icu_ctlregs
    import icu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CR_AW-1:0]  waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [CR_AW-1:0]  raddr,
    input  logic              enter_go,
    input  logic              ret_go,
    output logic [XLEN-1:0]   rdata,
    output logic              master_en,
    output logic [NLINES-1:0] mask
);

    logic [XLEN-1:0]   en_q, en_d;
    logic [XLEN-1:0]   save_q, save_d;
    logic [NLINES-1:0] mask_q, mask_d;

    // Software write first, then the hardware sequence on top of it.
    always_comb begin
        en_d   = en_q;
        save_d = save_q;
        mask_d = mask_q;
        if (we) begin
            unique case (waddr)
                CR_ENABLE: en_d   = wdata;
                CR_SAVE:   save_d = wdata;
                CR_MASK:   mask_d = wdata[NLINES-1:0];
                default:   ;
            endcase
        end
        if (enter_go) begin
            save_d    = en_d;
            en_d[0]   = 1'b0;
        end else if (ret_go) begin
            en_d = save_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            save_q <= '0;
            mask_q <= '0;
        end else begin
            en_q   <= en_d;
            save_q <= save_d;
            mask_q <= mask_d;
        end
    end

    always_comb begin
        unique case (raddr)
            CR_ENABLE: rdata = en_q;
            CR_SAVE:   rdata = save_q;
            CR_MASK:   rdata = XLEN'(mask_q);
            default:   rdata = '0;
        endcase
    end

    assign master_en = en_q[0];
    assign mask      = mask_q;

    AST_ENTER_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        enter_go |=> !en_q[0]); // R6

    AST_RET_RESTORES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ret_go |=> (en_q == $past(save_q))); // R7

endmodule

// File: rtl/icu_seq.sv
module icu_seq
    import icu_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h0000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_done,
    input  logic            eret,
    input  logic            take_req,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] ea_in,
    output logic            enter_go,
    output logic            ret_go,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_target,
    output logic            ea_we,
    output logic [XLEN-1:0] ea_wdata
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    icu_state_e      state_q, state_d;
    logic [XLEN-1:0] next_pc_q;
    logic [XLEN-1:0] ret_pc_q;

    // Transition decode; boundaries are seen only in ST_RUN.
    always_comb begin
        state_d  = state_q;
        enter_go = 1'b0;
        ret_go   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (eret) begin
                    ret_go  = 1'b1;
                    state_d = ST_RETURN;
                end else if (insn_done && take_req) begin
                    enter_go = 1'b1;
                    state_d  = ST_ENTER;
                end
            end
            ST_ENTER:  state_d = ST_RUN;
            ST_RETURN: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_pc_q <= '0;
            ret_pc_q  <= '0;
        end else begin
            if (enter_go) next_pc_q <= cur_pc + INSN_BYTES;
            if (ret_go)   ret_pc_q  <= ea_in;
        end
    end

    // Outputs from state.
    always_comb begin
        pc_load   = 1'b0;
        pc_target = '0;
        ea_we     = 1'b0;
        ea_wdata  = next_pc_q;
        unique case (state_q)
            ST_RUN: ;
            ST_ENTER: begin
                pc_load   = 1'b1;
                pc_target = HANDLER_ADDR;
                ea_we     = 1'b1;
            end
            ST_RETURN: begin
                pc_load   = 1'b1;
                pc_target = ret_pc_q;
            end
            default: ;
        endcase
    end

    AST_REDIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load); // R10

    AST_EA_IS_NEXT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        enter_go |=> (ea_we && ea_wdata == $past(cur_pc) + INSN_BYTES)); // R5

endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
    import icu_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              NLINES       = 32,
    parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h0000_0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq,
    input  logic              insn_done,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              eret,
    input  logic [XLEN-1:0]   ea_in,
    input  logic              ctl_we,
    input  logic [2:0]        ctl_waddr,
    input  logic [XLEN-1:0]   ctl_wdata,
    input  logic [2:0]        ctl_raddr,
    output logic [XLEN-1:0]   ctl_rdata,
    output logic              pc_load,
    output logic [XLEN-1:0]   pc_target,
    output logic              ea_we,
    output logic [XLEN-1:0]   ea_wdata,
    output logic [NLINES-1:0] pending
);

    logic              master_en;
    logic [NLINES-1:0] mask;
    logic              take_req;
    logic              enter_go;
    logic              ret_go;

    icu_ctlregs #(.XLEN(XLEN), .NLINES(NLINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ctl_we),
        .waddr     (ctl_waddr),
        .wdata     (ctl_wdata),
        .raddr     (ctl_raddr),
        .enter_go  (enter_go),
        .ret_go    (ret_go),
        .rdata     (ctl_rdata),
        .master_en (master_en),
        .mask      (mask)
    );

    icu_pending #(.NLINES(NLINES)) u_pend (
        .irq       (irq),
        .mask      (mask),
        .master_en (master_en),
        .pending   (pending),
        .take_req  (take_req)
    );

    icu_seq #(.XLEN(XLEN), .HANDLER_ADDR(HANDLER_ADDR)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .eret      (eret),
        .take_req  (take_req),
        .cur_pc    (cur_pc),
        .ea_in     (ea_in),
        .enter_go  (enter_go),
        .ret_go    (ret_go),
        .pc_load   (pc_load),
        .pc_target (pc_target),
        .ea_we     (ea_we),
        .ea_wdata  (ea_wdata)
    );

    AST_NO_TAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && !master_en) |=> !ea_we); // R4

endmodule

// File: tb/sim_irq_ctl_unit.sv
module sim_irq_ctl_unit;

    localparam logic [31:0] HADDR = 32'h0000_0180;

    typedef struct {
        bit          is_enter;
        logic [31:0] target;
        logic [31:0] ea;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        insn_done = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        eret = 1'b0;
    logic [31:0] ea_in = '0;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_waddr = '0;
    logic [31:0] ctl_wdata = '0;
    logic [2:0]  ctl_raddr = '0;
    logic [31:0] ctl_rdata;
    logic        pc_load;
    logic [31:0] pc_target;
    logic        ea_we;
    logic [31:0] ea_wdata;
    logic [31:0] pending;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    irq_ctl_unit #(.XLEN(32), .NLINES(32), .HANDLER_ADDR(HADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .irq(irq), .insn_done(insn_done),
        .cur_pc(cur_pc), .eret(eret), .ea_in(ea_in), .ctl_we(ctl_we),
        .ctl_waddr(ctl_waddr), .ctl_wdata(ctl_wdata), .ctl_raddr(ctl_raddr),
        .ctl_rdata(ctl_rdata), .pc_load(pc_load), .pc_target(pc_target),
        .ea_we(ea_we), .ea_wdata(ea_wdata), .pending(pending)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: every redirect must match the head of the scoreboard.
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n && pc_load) begin
            if (q.size() == 0) begin
                chk("R10 unexpected redirect", 32'd1, 32'd0);
            end else begin
                e = q.pop_front();
                chk("R5/R7 redirect target", pc_target, e.target);
                chk("R5/R7 ea write enable", {31'b0, ea_we}, {31'b0, e.is_enter});
                if (e.is_enter) chk("R5 return address", ea_wdata, e.ea);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        ctl_we = 1'b1; ctl_waddr = a; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        ctl_raddr = a;
        #1;
        chk(tag, ctl_rdata, exp);
    endtask

    task automatic boundary(input logic [31:0] pc, input bit take, input string tag);
        cur_pc = pc; insn_done = 1'b1;
        if (take) q.push_back('{1'b1, HADDR, pc + 32'd4});
        @(negedge clk);
        insn_done = 1'b0;
        chk(tag, {31'b0, pc_load}, {31'b0, take});
        @(negedge clk);
    endtask

    task automatic do_eret(input logic [31:0] ea, input string tag);
        eret = 1'b1; ea_in = ea;
        q.push_back('{1'b0, ea, 32'h0});
        @(negedge clk);
        eret = 1'b0;
        chk(tag, {31'b0, pc_load}, 32'd1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pc_load in reset", {31'b0, pc_load}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd0, 32'h0, "R1 reg0 reset");
        rd(3'd1, 32'h0, "R1 reg1 reset");
        rd(3'd3, 32'h0, "R1 reg3 reset");
        chk("R1 pending reset", pending, 32'h0);
        chk("R1 ea_we reset", {31'b0, ea_we}, 32'd0);

        // R2 register access
        wr(3'd1, 32'hA5A5_0001);
        wr(3'd3, 32'h0000_0002);
        rd(3'd1, 32'hA5A5_0001, "R2 reg1 readback");
        rd(3'd3, 32'h0000_0002, "R2 reg3 readback");
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd2, 32'h0, "R2 reg2 reads zero");
        rd(3'd5, 32'h0, "R2 reg5 reads zero");
        rd(3'd0, 32'h0, "R2 reg0 unchanged by unused index");
        rd(3'd1, 32'hA5A5_0001, "R2 reg1 unchanged by unused index");
        rd(3'd3, 32'h0000_0002, "R2 reg3 unchanged by unused index");

        // R3 pending with master disabled
        irq = 32'h0000_0006;
        #1;
        chk("R3 pending with enable off", pending, 32'h0000_0002);

        // R4 gates
        boundary(32'h0000_1000, 1'b0, "R4 enable off no take");
        wr(3'd0, 32'h0000_0005);
        irq = 32'h0000_0004;
        boundary(32'h0000_1000, 1'b0, "R4 masked line no take");
        irq = 32'h0000_0002;
        repeat (3) @(negedge clk);
        chk("R4 no boundary no take", {31'b0, pc_load}, 32'd0);

        // R5/R6 acceptance
        boundary(32'h0000_1000, 1'b1, "R5 accept");
        rd(3'd0, 32'h0000_0004, "R6 reg0 bit0 cleared");
        rd(3'd1, 32'h0000_0005, "R6 reg1 saved copy");
        chk("R5 redirect lasts one cycle", {31'b0, pc_load}, 32'd0);

        // R7 return
        do_eret(32'h0000_1004, "R7 return redirect");
        rd(3'd0, 32'h0000_0005, "R7 reg0 restored");

        // R9 return and boundary together, then R10 boundary during return cycle
        eret = 1'b1; ea_in = 32'h0000_2000; insn_done = 1'b1; cur_pc = 32'h0000_3000;
        q.push_back('{1'b0, 32'h0000_2000, 32'h0});
        @(negedge clk);
        eret = 1'b0;
        chk("R9 return wins", {31'b0, ea_we}, 32'd0);
        @(negedge clk);
        chk("R10 boundary in redirect cycle ignored", {31'b0, pc_load}, 32'd0);
        insn_done = 1'b0;
        boundary(32'h0000_3000, 1'b1, "R10 accept after redirect");
        rd(3'd0, 32'h0000_0004, "R6 reg0 after second accept");
        do_eret(32'h0000_3004, "R7 second return");

        // R8 write to reg0 together with acceptance
        ctl_we = 1'b1; ctl_waddr = 3'd0; ctl_wdata = 32'h0000_0009;
        q.push_back('{1'b1, HADDR, 32'h0000_4004});
        cur_pc = 32'h0000_4000; insn_done = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0; insn_done = 1'b0;
        chk("R8 accept with write", {31'b0, ea_we}, 32'd1);
        @(negedge clk);
        rd(3'd1, 32'h0000_0009, "R8 reg1 holds written value");
        rd(3'd0, 32'h0000_0008, "R8 reg0 written value bit0 cleared");
        do_eret(32'h0000_4004, "R7 third return");
        rd(3'd0, 32'h0000_0009, "R7 reg0 restored to written value");

        // R3/R5 top line and address wrap
        wr(3'd3, 32'hFFFF_0000);
        irq = 32'h8000_0001;
        #1;
        chk("R3 pending top line", pending, 32'h8000_0000);
        boundary(32'hFFFF_FFFC, 1'b1, "R5 top line accept wrap");

        irq = '0;
        repeat (2) @(negedge clk);
        chk("R5 scoreboard drained", q.size(), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule